// File: doc/BRIEF.md
# Packed Integer Compare-to-Mask Unit

This block takes two 512-bit integer vectors and compares them element by element. It returns a mask with one bit per element. Elements are 32 or 64 bits wide, and they are ordered either as two's-complement or as unsigned values. A three-bit predicate code selects one of eight relations: the six ordinary relations plus constant false and constant true.

The active vector length is given as a count of 128-bit lanes. Mask bits for elements beyond that length are forced to zero. An optional write mask then clears result bits.

The caller presents both operands and the control fields, and raises `start` for one cycle. On the next cycle the mask appears on `mask_out` and `mask_vld` pulses high. The mask then holds until the next `start`.

Top module: `vec_cmp_mask`

## Requirements
- R1: Only bits [2:0] of `pred_imm` select the relation, and bits [7:3] have no effect. The encoding is 0 equal, 1 less-than, 2 less-or-equal, 3 never, 4 not-equal, 5 greater-or-equal, 6 greater-than, 7 always. Each relation is read as "A rel B".
- R2: With `is_signed`=1, codes 1, 2, 5 and 6 order the elements as two's-complement numbers.
- R3: With `is_signed`=0, codes 1, 2, 5 and 6 order the elements as unsigned numbers. Codes 0, 3, 4 and 7 give the same result in both orderings.
- R4: With `elem64`=0, the 32-bit element at bits [32i+31:32i] of the operands drives mask bit i. Each 128-bit lane therefore fills 4 bits, and the highest lane lands in the top bits.
- R5: With `elem64`=1, the 64-bit element at bits [64j+63:64j] drives mask bit j. Each lane fills 2 bits, and `mask_out` bits [15:8] are zero.
- R6: `lane_cnt` values 1 and 2 select 1 and 2 active lanes, and any other value selects 4 lanes. Mask bits for elements outside the active lanes are zero.
- R7: With `wm_en`=1, the result is ANDed with `wm_val`. Only `wm_val[7:0]` is used for 64-bit elements. With `wm_en`=0, `wm_val` has no effect.
- R8: `mask_out` takes the new result at the clock edge where `start` is sampled high. `mask_vld` is high for exactly the following cycle. Without `start`, `mask_out` holds its value whatever the inputs do.
- R9: After reset, `mask_out` is zero and `mask_vld` is low.
- R10: Code 3 yields an all-zero mask. Code 7 sets every bit for an active element, subject to the write mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Compare request; inputs are sampled when it is high |
| opa | input | 512 | Operand A (left side of the relation) |
| opb | input | 512 | Operand B (right side of the relation) |
| elem64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| is_signed | input | 1 | 1: two's-complement ordering, 0: unsigned ordering |
| pred_imm | input | 8 | Predicate immediate; only bits [2:0] are used |
| lane_cnt | input | 3 | Number of active 128-bit lanes (1, 2, else 4) |
| wm_en | input | 1 | Enables write-mask gating |
| wm_val | input | 16 | Write mask value |
| mask_out | output | 16 | Registered compare mask |
| mask_vld | output | 1 | One-cycle pulse when a new mask is present |

## Verification
The bench sweeps every predicate, both element sizes, both orderings, all eight lane-count codes and both write-mask settings. It uses operands built from boundary values (0, 1, the most negative and most positive numbers, all-ones) so that signed and unsigned orderings disagree. A design that flipped the sign bit in the wrong mode would then invert the less-than results on those pairs. If length clipping or the 8-bit write-mask width were wrong, stray upper mask bits would show up on the 1-lane, 2-lane and 64-bit cases. A directed pattern with one unequal element at a known position catches a lane or bit ordering that was reversed or shifted. The bench also changes the operands with `start` low, which exposes a mask register that loads when it should hold.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  localparam int LANE_W     = 128;
  localparam int DW         = 32;
  localparam int QW         = 64;
  localparam int D_PER_LANE = LANE_W / DW;
  localparam int Q_PER_LANE = LANE_W / QW;

  typedef enum logic [2:0] {
    PR_EQ    = 3'd0,
    PR_LT    = 3'd1,
    PR_LE    = 3'd2,
    PR_NEVER = 3'd3,
    PR_NE    = 3'd4,
    PR_GE    = 3'd5,
    PR_GT    = 3'd6,
    PR_ALWAYS = 3'd7
  } pred_e;

  // Ordering by flipping the sign bit when signed: two's complement maps
  // onto unsigned order after that flip.
  function automatic logic ord_lt32(logic [DW-1:0] a, logic [DW-1:0] b, logic sg);
    return {a[DW-1] ^ sg, a[DW-2:0]} < {b[DW-1] ^ sg, b[DW-2:0]};
  endfunction

  function automatic logic ord_lt64(logic [QW-1:0] a, logic [QW-1:0] b, logic sg);
    return {a[QW-1] ^ sg, a[QW-2:0]} < {b[QW-1] ^ sg, b[QW-2:0]};
  endfunction

  function automatic logic pred_hit(pred_e p, logic eq, logic lt);
    logic r;
    case (p)
      PR_EQ:    r = eq;
      PR_LT:    r = lt;
      PR_LE:    r = lt | eq;
      PR_NEVER: r = 1'b0;
      PR_NE:    r = ~eq;
      PR_GE:    r = ~lt;
      PR_GT:    r = ~(lt | eq);
      default:  r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic int lanes_of(logic [2:0] code, int max_lanes);
    int n;
    case (code)
      3'd1:    n = 1;
      3'd2:    n = 2;
      default: n = max_lanes;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/vcm_lane.sv
module vcm_lane
  import vcm_pkg::*;
(
  input  logic [LANE_W-1:0]     a_i,
  input  logic [LANE_W-1:0]     b_i,
  input  logic                  sg_i,
  input  pred_e                 pred_i,
  output logic [D_PER_LANE-1:0] dhit_o,
  output logic [Q_PER_LANE-1:0] qhit_o
);

  for (genvar d = 0; d < D_PER_LANE; d++) begin : g_dw
    logic [DW-1:0] ea, eb;
    assign ea = a_i[d*DW +: DW];
    assign eb = b_i[d*DW +: DW];
    assign dhit_o[d] = pred_hit(pred_i, ea == eb, ord_lt32(ea, eb, sg_i));
  end

  for (genvar q = 0; q < Q_PER_LANE; q++) begin : g_qw
    logic [QW-1:0] ea, eb;
    assign ea = a_i[q*QW +: QW];
    assign eb = b_i[q*QW +: QW];
    assign qhit_o[q] = pred_hit(pred_i, ea == eb, ord_lt64(ea, eb, sg_i));
  end

endmodule

// File: rtl/vcm_pack.sv
module vcm_pack
  import vcm_pkg::*;
#(
  parameter  int MAX_LANES = 4,
  localparam int MASK_W    = MAX_LANES * D_PER_LANE,
  localparam int QMASK_W   = MAX_LANES * Q_PER_LANE,
  localparam int LC_W      = $clog2(MAX_LANES + 1)
) (
  input  logic [MASK_W-1:0]  dhit_i,
  input  logic [QMASK_W-1:0] qhit_i,
  input  logic               e64_i,
  input  logic [LC_W-1:0]    lanes_i,
  input  logic               wm_en_i,
  input  logic [MASK_W-1:0]  wm_val_i,
  output logic [MASK_W-1:0]  raw_o,
  output logic [MASK_W-1:0]  mask_o
);

  int n_act;
  assign n_act = e64_i ? int'(lanes_i) * Q_PER_LANE : int'(lanes_i) * D_PER_LANE;

  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    logic src, keep;
    if (i < QMASK_W) begin : g_shared
      assign src  = e64_i ? qhit_i[i] : dhit_i[i];
      assign keep = ~wm_en_i | wm_val_i[i];
    end else begin : g_dw_only
      assign src  = ~e64_i & dhit_i[i];
      assign keep = ~wm_en_i | (wm_val_i[i] & ~e64_i);
    end
    assign raw_o[i]  = src & (i < n_act);
    assign mask_o[i] = raw_o[i] & keep;
  end

endmodule

// File: rtl/vec_cmp_mask.sv
module vec_cmp_mask
  import vcm_pkg::*;
#(
  parameter  int MAX_LANES = 4,
  localparam int VEC_W     = MAX_LANES * LANE_W,
  localparam int MASK_W    = MAX_LANES * D_PER_LANE,
  localparam int QMASK_W   = MAX_LANES * Q_PER_LANE,
  localparam int LC_W      = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  opa,
  input  logic [VEC_W-1:0]  opb,
  input  logic              elem64,
  input  logic              is_signed,
  input  logic [7:0]        pred_imm,
  input  logic [2:0]        lane_cnt,
  input  logic              wm_en,
  input  logic [MASK_W-1:0] wm_val,
  output logic [MASK_W-1:0] mask_out,
  output logic              mask_vld
);

  pred_e              pred;
  logic [4:0]         unused_imm_hi;
  logic [LC_W-1:0]    lanes_act;
  logic [MASK_W-1:0]  dhit_all;
  logic [QMASK_W-1:0] qhit_all;
  logic [MASK_W-1:0]  hit_raw;
  logic [MASK_W-1:0]  hit_gated;

  assign pred          = pred_e'(pred_imm[2:0]);
  assign unused_imm_hi = pred_imm[7:3];
  assign lanes_act     = LC_W'(lanes_of(lane_cnt, MAX_LANES));

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    vcm_lane u_lane (
      .a_i    (opa[l*LANE_W +: LANE_W]),
      .b_i    (opb[l*LANE_W +: LANE_W]),
      .sg_i   (is_signed),
      .pred_i (pred),
      .dhit_o (dhit_all[l*D_PER_LANE +: D_PER_LANE]),
      .qhit_o (qhit_all[l*Q_PER_LANE +: Q_PER_LANE])
    );
  end

  vcm_pack #(.MAX_LANES(MAX_LANES)) u_pack (
    .dhit_i   (dhit_all),
    .qhit_i   (qhit_all),
    .e64_i    (elem64),
    .lanes_i  (lanes_act),
    .wm_en_i  (wm_en),
    .wm_val_i (wm_val),
    .raw_o    (hit_raw),
    .mask_o   (hit_gated)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_out <= '0;
      mask_vld <= 1'b0;
    end else begin
      mask_vld <= start;
      if (start) mask_out <= hit_gated;
    end
  end

endmodule

// File: rtl/vec_cmp_mask_chk.sv
module vec_cmp_mask_chk
  import vcm_pkg::*;
#(
  parameter int MASK_W = 16,
  parameter int LC_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              elem64,
  input logic [7:0]        pred_imm,
  input logic [LC_W-1:0]   lanes_act,
  input logic              wm_en,
  input logic [MASK_W-1:0] wm_val,
  input logic [MASK_W-1:0] hit_raw,
  input logic [MASK_W-1:0] mask_out,
  input logic              mask_vld
);

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mask_vld);                                              // R8
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !mask_vld);                                            // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mask_out));                                    // R8
  AST_WM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vld && $past(wm_en)) |-> ((mask_out & ~$past(wm_val)) == '0)); // R7
  AST_WM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vld && !$past(wm_en)) |-> (mask_out == $past(hit_raw)));    // R7
  AST_QW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vld && $past(elem64)) |-> (mask_out[MASK_W-1:MASK_W/2] == '0)); // R5
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vld && $past(pred_imm[2:0]) == 3'd3) |-> (mask_out == '0)); // R10
  AST_LEN_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
    mask_vld |-> ((mask_out >> (int'($past(lanes_act)) *
      ($past(elem64) ? Q_PER_LANE : D_PER_LANE))) == '0));            // R6

endmodule

bind vec_cmp_mask vec_cmp_mask_chk #(.MASK_W(MASK_W), .LC_W(LC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .elem64    (elem64),
  .pred_imm  (pred_imm),
  .lanes_act (lanes_act),
  .wm_en     (wm_en),
  .wm_val    (wm_val),
  .hit_raw   (hit_raw),
  .mask_out  (mask_out),
  .mask_vld  (mask_vld)
);

// File: tb/tb_vec_cmp_mask.sv
`timescale 1ns/1ps
module tb_vec_cmp_mask;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [511:0] opa = '0, opb = '0;
  logic         elem64 = 1'b0, is_signed = 1'b0;
  logic [7:0]   pred_imm = '0;
  logic [2:0]   lane_cnt = 3'd4;
  logic         wm_en = 1'b0;
  logic [15:0]  wm_val = '0;
  logic [15:0]  mask_out;
  logic         mask_vld;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  vec_cmp_mask dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .elem64(elem64), .is_signed(is_signed), .pred_imm(pred_imm),
    .lane_cnt(lane_cnt), .wm_en(wm_en), .wm_val(wm_val),
    .mask_out(mask_out), .mask_vld(mask_vld)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: widen each element to 65 bits and compare numerically.
  function automatic logic [15:0] model(logic [511:0] a, logic [511:0] b, logic e64,
                                        logic sg, logic [7:0] imm, logic [2:0] lc,
                                        logic we, logic [15:0] wv);
    logic [15:0] r = '0;
    int lanes = (lc == 3'd1) ? 1 : (lc == 3'd2) ? 2 : 4;
    int n = e64 ? lanes * 2 : lanes * 4;
    for (int i = 0; i < 16; i++) begin
      logic signed [64:0] x, y;
      logic lt, eq, h;
      if (i < n) begin
        if (e64) begin
          x = sg ? {a[64*i+63], a[64*i +: 64]} : {1'b0, a[64*i +: 64]};
          y = sg ? {b[64*i+63], b[64*i +: 64]} : {1'b0, b[64*i +: 64]};
        end else begin
          x = sg ? {{33{a[32*i+31]}}, a[32*i +: 32]} : {33'b0, a[32*i +: 32]};
          y = sg ? {{33{b[32*i+31]}}, b[32*i +: 32]} : {33'b0, b[32*i +: 32]};
        end
        lt = x < y;
        eq = x == y;
        case (imm[2:0])
          3'd0: h = eq;
          3'd1: h = lt;
          3'd2: h = lt || eq;
          3'd3: h = 1'b0;
          3'd4: h = !eq;
          3'd5: h = !lt;
          3'd6: h = !lt && !eq;
          default: h = 1'b1;
        endcase
        r[i] = h;
      end
    end
    if (we) r = r & (e64 ? {8'h00, wv[7:0]} : wv);
    return r;
  endfunction

  function automatic logic [31:0] pick(int k);
    case (k % 8)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0002;
      3: return 32'h7fff_ffff;
      4: return 32'h8000_0000;
      5: return 32'hffff_ffff;
      6: return 32'hffff_fffe;
      default: return 32'h8000_0001;
    endcase
  endfunction

  task automatic run_trial(string tag, logic [511:0] a, logic [511:0] b, logic e64,
                           logic sg, logic [7:0] imm, logic [2:0] lc,
                           logic we, logic [15:0] wv);
    logic [15:0] exp;
    @(negedge clk);
    opa = a; opb = b; elem64 = e64; is_signed = sg; pred_imm = imm;
    lane_cnt = lc; wm_en = we; wm_val = wv; start = 1'b1;
    exp = model(a, b, e64, sg, imm, lc, we, wv);
    @(negedge clk);
    start = 1'b0;
    chk(tag, mask_out, exp);
    chk("R8 valid pulse", {15'b0, mask_vld}, 16'h0001);
    opa = ~opa; pred_imm = pred_imm ^ 8'h04;
    @(negedge clk);
    chk("R8 valid drop", {15'b0, mask_vld}, 16'h0000);
    chk("R8 hold", mask_out, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [511:0] a, b;
    repeat (3) @(negedge clk);
    chk("R9 reset mask", mask_out, 16'h0000);
    chk("R9 reset valid", {15'b0, mask_vld}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: single unequal 32-bit element at index 5
    for (int k = 0; k < 16; k++) a[32*k +: 32] = 32'h0101_0101 * (k + 1);
    b = a; b[32*5 +: 32] = 32'h0;
    run_trial("R4 position", a, b, 1'b0, 1'b0, 8'd0, 3'd4, 1'b0, 16'h0);
    // R5: two lanes of equal 64-bit elements fill bits [3:0] only
    run_trial("R5 position", a, a, 1'b1, 1'b0, 8'd0, 3'd2, 1'b0, 16'h0);

    for (int p = 0; p < 8; p++)
      for (int e = 0; e < 2; e++)
        for (int s = 0; s < 2; s++)
          for (int lc = 0; lc < 8; lc++)
            for (int w = 0; w < 2; w++)
              for (int rep = 0; rep < 3; rep++) begin
                logic [7:0] imm;
                string tag;
                for (int k = 0; k < 16; k++) a[32*k +: 32] = pick($urandom);
                for (int j = 0; j < 8; j++) begin
                  if ($urandom % 2 == 0) b[64*j +: 64] = a[64*j +: 64];
                  else begin
                    b[64*j +: 32]      = pick($urandom);
                    b[64*j + 32 +: 32] = (e == 0 && $urandom % 2 == 0) ?
                                         a[64*j + 32 +: 32] : pick($urandom);
                  end
                end
                imm = {(rep == 2) ? 5'($urandom) | 5'h01 : 5'h00, 3'(p)};
                if (lc != 1 && lc != 2 && lc != 4) tag = "R6 lane count";
                else if (w == 1)                   tag = "R7 write mask";
                else if (p == 3 || p == 7)         tag = "R10 constant";
                else if (rep == 2)                 tag = "R1 upper imm";
                else if (e == 1)                   tag = "R5 qword";
                else if (s == 1)                   tag = "R2 signed";
                else                               tag = "R3 unsigned";
                run_trial(tag, a, b, 1'(e), 1'(s), imm, 3'(lc), 1'(w), 16'($urandom));
              end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule